// File: doc/BRIEF.md
# Per-Load Stride Prefetch Predictor

This block learns, for each load instruction, the constant distance between the data addresses that load touches on successive executions. It then proposes a prefetch for the address that load is likely to touch next. Each retired load arrives as a one-cycle strobe carrying two addresses: the instruction address of the load and the data address it accessed. The block looks up a small direct-mapped table using the instruction address, so each load instruction trains its own entry. This works the way a branch predictor keeps separate state for each branch.

An entry holds four things: a partial tag taken from the instruction address, the last data address seen, the last observed stride, and a 2-bit saturating confidence counter. When consecutive strides agree, confidence rises. Once confidence reaches 2, the block emits a prefetch request for the current data address plus the stride, one cycle after the load. Strides can be forward or backward but are bounded in magnitude, and a zero stride never leads to a request. Fetching memory and interacting with the cache are left to the consumer of the request.

Top module: `stride_table`

## Requirements
- R1: The table entry is chosen by instruction-address bits [3:0], and bits [11:4] form the tag. Two loads with different indices train independently, even when their data addresses interleave.
- R2: On a tag hit, the stride is updated to the current data address minus the entry's stored last address. The stored last address is then replaced by the current data address.
- R3: A prefetch request carries the current data address plus the updated stride. For example, loads at 0x100, 0x200, 0x300 and 0x400 produce a request for 0x500.
- R4: Negative strides are learned and prefetched the same way as positive ones.
- R5: A stride whose magnitude is 2048 or less is usable. A difference whose magnitude exceeds 2048 is recorded as a zero stride and never produces a request.
- R6: Confidence rises by one when the new stride equals the stored one, and falls by one otherwise. A request is issued only when the updated confidence is 2 or more.
- R7: Confidence saturates at 3 and at 0. After a long matching run, one differing stride drops confidence to 2, so a request is still issued using the new stride. A second differing stride drops confidence to 1 and suppresses requests.
- R8: A zero stride never issues a request, whatever the confidence.
- R9: On a tag mismatch or an invalid entry, the entry is rewritten with the new tag and address, a zero stride and zero confidence, and no request is issued.
- R10: After reset, every entry is invalid and pf_valid is low.
- R11: pf_valid and pf_addr are registered. A request appears exactly one cycle after the load strobe, and never in a cycle that follows no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load retires this cycle |
| ld_pc | input | 32 | Instruction address of the load |
| ld_addr | input | 32 | Data address of the load |
| pf_valid | output | 1 | Prefetch request valid |
| pf_addr | output | 32 | Prefetch target address |

## Verification
The bench sweeps a set of strides through fresh entries: small and large forward strides, backward strides, zero, and values just inside and just outside the ±2048 bound. Each sweep shows whether the request starts on exactly the fourth load and stops at the bound. A saturation run followed by two differing strides tells a saturating counter apart from one that wraps or resets on a mismatch. Interleaved loads from two indices, and an aliasing pair that shares an index but has different tags, separate per-instruction training from sharing and show that replacement clears the learned state. All expected results come from an arithmetic model in the bench.

// File: rtl/stride_table.sv
module stride_table #(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 16,
  parameter int TAG_W      = 8,
  parameter int MAX_STRIDE = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int SW    = $clog2(MAX_STRIDE) + 2;
  localparam logic signed [ADDR_W-1:0] LIM = ADDR_W'(MAX_STRIDE);

  logic [TAG_W-1:0]     tag_q  [ENTRIES];
  logic [ADDR_W-1:0]    last_q [ENTRIES];
  logic signed [SW-1:0] str_q  [ENTRIES];
  logic [1:0]           conf_q [ENTRIES];
  logic [ENTRIES-1:0]   vld_q;

  logic [IDX_W-1:0]          idx;
  logic [TAG_W-1:0]          tag;
  logic                      hit;
  logic signed [ADDR_W-1:0]  diff;
  logic                      in_rng;
  logic signed [SW-1:0]      new_str;
  logic                      match;
  logic [1:0]                new_conf;
  logic                      issue;

  assign idx      = ld_pc[IDX_W-1:0];
  assign tag      = ld_pc[IDX_W +: TAG_W];
  assign hit      = vld_q[idx] && (tag_q[idx] == tag);
  assign diff     = $signed(ld_addr - last_q[idx]);
  assign in_rng   = (diff <= LIM) && (diff >= -LIM);
  assign new_str  = in_rng ? diff[SW-1:0] : '0;
  assign match    = (new_str == str_q[idx]);
  assign new_conf = match ? ((conf_q[idx] == 2'd3) ? 2'd3 : conf_q[idx] + 2'd1)
                          : ((conf_q[idx] == 2'd0) ? 2'd0 : conf_q[idx] - 2'd1);
  assign issue    = ld_valid && hit && new_conf[1] && (new_str != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= '0;
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      pf_valid <= issue;
      if (issue)
        pf_addr <= ld_addr + {{(ADDR_W-SW){new_str[SW-1]}}, new_str};
      if (ld_valid)
        vld_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && ld_valid) begin
      tag_q[idx]  <= tag;
      last_q[idx] <= ld_addr;
      str_q[idx]  <= hit ? new_str : '0;
      conf_q[idx] <= hit ? new_conf : 2'd0;
    end
  end

  a_r11_req_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(ld_valid));

  a_r8_no_zero_target: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr != $past(ld_addr)));

  a_r5_bounded_step: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (($signed(pf_addr - $past(ld_addr)) <= LIM) &&
                  ($signed(pf_addr - $past(ld_addr)) >= -LIM)));

  a_r9_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !hit) |=> !pf_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !pf_valid);
endmodule

// File: tb/stride_table_tb.sv
module stride_table_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_pc = '0;
  logic [31:0] ld_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int total = 0;
  int bad = 0;

  logic [7:0]  m_tag  [16];
  logic [31:0] m_last [16];
  int          m_str  [16];
  int          m_conf [16];
  logic        m_vld  [16];

  stride_table u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
    .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  always #10 clk = ~clk;

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic av, input logic [31:0] aa,
                       input logic ev, input logic [31:0] ea);
    total++;
    if (av !== ev || (ev && aa !== ea)) begin
      bad++;
      $display("FAIL %s: actual valid=%0b addr=%h expected valid=%0b addr=%h",
               req, av, aa, ev, ea);
    end
  endtask

  task automatic load(input string req, input logic [31:0] pc, input logic [31:0] a);
    int i; int d; int e; logic ev; logic [31:0] ea;
    i = pc[3:0];
    ev = 1'b0; ea = '0;
    if (m_vld[i] && m_tag[i] == pc[11:4]) begin
      d = $signed(a - m_last[i]);
      e = (d <= 2048 && d >= -2048) ? d : 0;
      if (e == m_str[i]) m_conf[i] = (m_conf[i] == 3) ? 3 : m_conf[i] + 1;
      else               m_conf[i] = (m_conf[i] == 0) ? 0 : m_conf[i] - 1;
      m_str[i] = e;
      if (m_conf[i] >= 2 && e != 0) begin ev = 1'b1; ea = a + e; end
    end else begin
      m_vld[i] = 1'b1; m_tag[i] = pc[11:4]; m_str[i] = 0; m_conf[i] = 0;
    end
    m_last[i] = a;
    ld_valid = 1'b1; ld_pc = pc; ld_addr = a;
    @(negedge clk);
    ld_valid = 1'b0;
    check(req, pf_valid, pf_addr, ev, ea);
  endtask

  initial begin
    automatic int strides[12] = '{1, -1, 4, -64, 256, -1000, 2048, -2048, 2049, -2049, 0, 4096};
    for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", pf_valid, pf_addr, 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", pf_valid, pf_addr, 1'b0, '0);
    check("R11", pf_valid, pf_addr, 1'b0, '0);

    // R3: classic 0x100 step example
    load("R3", 32'h0000_1003, 32'h100);
    load("R3", 32'h0000_1003, 32'h200);
    load("R3", 32'h0000_1003, 32'h300);
    load("R3", 32'h0000_1003, 32'h400);
    check("R3", pf_valid, pf_addr, 1'b1, 32'h500);
    @(negedge clk);
    check("R11", pf_valid, pf_addr, 1'b0, '0);

    // R2 R4 R5 R8 R6: stride sweep, each on a fresh entry (new tag, index 5)
    foreach (strides[k]) begin
      logic [31:0] base;
      base = 32'h0010_0000 + 32'(k) * 32'h1_0000;
      for (int n = 0; n < 6; n++)
        load(strides[k] < 0 ? "R4" : (strides[k] == 0 ? "R8" :
             (strides[k] > 2048 || strides[k] < -2048) ? "R5" : "R2"),
             32'h0000_0005 | (32'(k + 1) << 4), base + n * strides[k]);
    end

    // R6 R7: saturation then two mismatching strides
    for (int n = 0; n < 6; n++) load("R6", 32'h0000_2007, 32'h8000 + n * 16);
    load("R7", 32'h0000_2007, 32'h8000 + 5 * 16 + 32);
    load("R7", 32'h0000_2007, 32'h8000 + 5 * 16 + 32 + 8);
    load("R7", 32'h0000_2007, 32'h8000 + 5 * 16 + 32 + 16);
    load("R7", 32'h0000_2007, 32'h8000 + 5 * 16 + 32 + 24);

    // R1: interleaved loads on two indices
    for (int n = 0; n < 6; n++) begin
      load("R1", 32'h0000_3009, 32'h4_0000 + n * 8);
      load("R1", 32'h0000_300A, 32'h4_0100 - n * 12);
    end

    // R9: alias on same index with a different tag clears training
    for (int n = 0; n < 5; n++) load("R9", 32'h0000_400C, 32'h9000 + n * 32);
    load("R9", 32'h0000_410C, 32'h9000 + 5 * 32);
    load("R9", 32'h0000_400C, 32'h9000 + 6 * 32);
    load("R9", 32'h0000_400C, 32'h9000 + 7 * 32);
    load("R9", 32'h0000_400C, 32'h9000 + 8 * 32);
    load("R9", 32'h0000_400C, 32'h9000 + 9 * 32);

    // R10: reset clears all entries
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
    check("R10", pf_valid, pf_addr, 1'b0, '0);
    load("R10", 32'h0000_400C, 32'h9000 + 10 * 32);
    load("R10", 32'h0000_400C, 32'h9000 + 11 * 32);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule